// File: doc/BRIEF.md
# Programmable Skew Clock Output Matrix

This block produces four pairs of clock outputs from a fast clock whose period is one time unit. A phase counter counts modulo N time units, and one such period is one nominal output cycle. A range input picks N, so it sets the nominal output frequency relative to the time-unit clock. Each pair has two three-level selects. Together they pick the pair's function: a signed phase offset in whole time units, a half-rate or quarter-rate divided clock, or an inverted clock. The offsets available differ by pair. The two outputs of a pair always carry the same waveform.

A new select or range value is taken up only when the phase counter wraps, so a setting change never shortens a pulse. Both divided functions come from one shared two-bit period counter, which keeps their falling edges together. A three-level test input bypasses the phase generator. In bypass, a reference input drives the outputs directly, and each output still applies its own divide or invert setting. All outputs are registered, so each one updates one clock after the state it reflects.

Top module: `skew_clk_matrix`

## Requirements
- R1: `rst` is synchronous. While it is high, the phase counter and the period counter are cleared and every output is low at the next clock edge. The select and range inputs are loaded as the active setting.
- R2: Each three-level input is a 2-bit code: 00 is LOW, 01 is MID and 10 is HIGH. Code 11 behaves exactly like MID.
- R3: The period N holds 44, 26 or 16 time units when the active range is LOW, MID or HIGH. The phase counter counts 0 to N-1 and then returns to 0.
- R4: For pairs 0 and 1, the level index is 3*hi+lo, with LOW=0, MID=1 and HIGH=2. The index gives a skew of index-4 time units, which covers -4 to +4.
- R5: For pairs 2 and 3, index 0 (both LOW) selects divide-by-2. Indices 1 to 7 give a skew of 2*index-8, which covers -6 to +6 in steps of 2.
- R6: Index 8 (both HIGH) selects divide-by-4 on pair 2. On pair 3 it selects a zero-skew inverted output, which is high when phase >= N/2.
- R7: A skewed output is high in the cycle after the phase counter holds a value p with ((p - skew) mod N) < N/2. A positive skew therefore delays the output and a negative skew advances it, with wraparound.
- R8: The two-bit period counter advances by one on each phase wrap. Divide-by-2 is high while the counter is odd, and divide-by-4 is high while it is 0 or 1. As a result, every falling edge of divide-by-4 coincides with a falling edge of divide-by-2.
- R9: Select and range changes take effect only on the clock edge where the phase counter wraps from N-1 to 0. Between wraps the outputs follow the previously active setting.
- R10: When `test_sel` is not LOW, a skewed output equals `ref_in` one cycle later and an inverted output equals its complement. The period counter then advances on each rising edge of `ref_in`, so divided outputs divide the reference.
- R11: `q0[k]` and `q1[k]` are always equal.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Time-unit clock |
| rst | input | 1 | Synchronous reset, active high |
| range_sel | input | 2 | Three-level period range code |
| test_sel | input | 2 | Three-level bypass control; LOW is normal operation |
| ref_in | input | 1 | Reference level used in bypass |
| fsel_hi | input | 8 | Upper select per pair, pair k at bits 2k+1:2k |
| fsel_lo | input | 8 | Lower select per pair, pair k at bits 2k+1:2k |
| q0 | output | 4 | First output of each pair |
| q1 | output | 4 | Second output of each pair |

## Verification
Every output register updates one edge after the phase, period-counter and reference values it depends on. A select or range change becomes visible one edge after the wrap that loads it. The bench keeps an arithmetic model of phase, period counter and active setting, advanced at each rising edge from the inputs held since the previous falling edge. It compares the outputs at the following falling edge, so each comparison meets its result exactly when it is due. Setting changes are applied mid-period, so the model's wrap-only loading is checked in the same cycle-exact way.

// File: rtl/skm_pkg.sv
package skm_pkg;
   localparam int NUM_PAIRS = 4;
   localparam int LVL_W     = 2;
   localparam int SKEW_MAX  = 6;
   localparam int MIN_N     = 2 * SKEW_MAX + 2;

   localparam logic [1:0] LVL_LOW  = 2'd0;
   localparam logic [1:0] LVL_MID  = 2'd1;
   localparam logic [1:0] LVL_HIGH = 2'd2;

   localparam int KIND_FINE   = 0;
   localparam int KIND_DIV4   = 1;
   localparam int KIND_INVERT = 2;

   typedef enum logic [1:0] {FN_SKEW, FN_DIV2, FN_DIV4, FN_INV} fn_e;

   typedef struct packed {
      fn_e               fn;
      logic signed [3:0] skew;
   } pair_cfg_t;

   function automatic logic [1:0] lvl_index(input logic [1:0] code);
      return (code == 2'b11) ? LVL_MID : code;
   endfunction

   function automatic int pair_kind(input int p);
      if (p < 2)
         return KIND_FINE;
      else if (p == 2)
         return KIND_DIV4;
      return KIND_INVERT;
   endfunction
endpackage

// File: rtl/skm_phase_gen.sv
module skm_phase_gen import skm_pkg::*; #(
   parameter int N_LOW  = 44,
   parameter int N_MID  = 26,
   parameter int N_HIGH = 16,
   parameter int PH_W   = 6
) (
   input  logic            clk,
   input  logic            rst,
   input  logic [1:0]      range_sel,
   input  logic            test_mode,
   input  logic            ref_in,
   output logic [PH_W-1:0] ph,
   output logic [PH_W-1:0] n_act,
   output logic            wrap,
   output logic [1:0]      dcnt,
   output logic [1:0]      range_act
);
   logic ref_q;
   logic ref_rise;

   always_comb begin
      case (lvl_index(range_act))
         LVL_LOW:  n_act = PH_W'(N_LOW);
         LVL_HIGH: n_act = PH_W'(N_HIGH);
         default:  n_act = PH_W'(N_MID);
      endcase
   end

   assign wrap     = (ph == n_act - 1'b1);
   assign ref_rise = ref_in & ~ref_q;

   always_ff @(posedge clk) begin
      if (rst) begin
         ph        <= '0;
         dcnt      <= '0;
         ref_q     <= 1'b0;
         range_act <= range_sel;
      end else begin
         ref_q <= ref_in;
         ph    <= wrap ? '0 : ph + 1'b1;
         if (wrap)
            range_act <= range_sel;
         if (test_mode) begin
            if (ref_rise)
               dcnt <= dcnt + 1'b1;
         end else if (wrap) begin
            dcnt <= dcnt + 1'b1;
         end
      end
   end
endmodule

// File: rtl/skm_func_decode.sv
module skm_func_decode import skm_pkg::*; #(
   parameter int KIND = KIND_FINE
) (
   input  logic [1:0] code_hi,
   input  logic [1:0] code_lo,
   output pair_cfg_t  cfg
);
   logic [4:0] idx;

   assign idx = 5'(lvl_index(code_hi)) * 5'd3 + 5'(lvl_index(code_lo));

   generate
      if (KIND == KIND_FINE) begin : g_fine
         always_comb begin
            cfg.fn   = FN_SKEW;
            cfg.skew = 4'($signed(idx) - 5'sd4);
         end
      end else if (KIND == KIND_DIV4 || KIND == KIND_INVERT) begin : g_coarse
         always_comb begin
            cfg.skew = '0;
            if (idx == 5'd0) begin
               cfg.fn = FN_DIV2;
            end else if (idx == 5'd8) begin
               cfg.fn = (KIND == KIND_DIV4) ? FN_DIV4 : FN_INV;
            end else begin
               cfg.fn   = FN_SKEW;
               cfg.skew = 4'($signed({idx[3:0], 1'b0}) - 5'sd8);
            end
         end
      end else begin : g_bad_kind
         $error("skm_func_decode: unknown KIND");
      end
   endgenerate
endmodule

// File: rtl/skm_pair_out.sv
module skm_pair_out import skm_pkg::*; #(
   parameter int PH_W = 6
) (
   input  logic            clk,
   input  logic            rst,
   input  pair_cfg_t       cfg,
   input  logic [PH_W-1:0] ph,
   input  logic [PH_W-1:0] n_act,
   input  logic [1:0]      dcnt,
   input  logic            test_mode,
   input  logic            ref_in,
   output logic            q0,
   output logic            q1
);
   localparam int SW = PH_W + 2;

   logic signed [SW-1:0] ph_s, n_s, half_s, sk_s, diff, wrapped;
   logic shifted_hi, zero_hi, nxt;

   always_comb begin
      ph_s   = $signed({2'b00, ph});
      n_s    = $signed({2'b00, n_act});
      half_s = n_s >>> 1;
      sk_s   = SW'(cfg.skew);
      diff   = ph_s - sk_s;
      if (diff < 0)
         wrapped = diff + n_s;
      else if (diff >= n_s)
         wrapped = diff - n_s;
      else
         wrapped = diff;
      shifted_hi = (wrapped < half_s);
      zero_hi    = (ph_s < half_s);
      case (cfg.fn)
         FN_DIV2: nxt = dcnt[0];
         FN_DIV4: nxt = ~dcnt[1];
         FN_INV:  nxt = test_mode ? ~ref_in : ~zero_hi;
         default: nxt = test_mode ? ref_in : shifted_hi;
      endcase
   end

   always_ff @(posedge clk) begin
      if (rst) begin
         q0 <= 1'b0;
         q1 <= 1'b0;
      end else begin
         q0 <= nxt;
         q1 <= nxt;
      end
   end
endmodule

// File: rtl/skew_clk_matrix.sv
module skew_clk_matrix import skm_pkg::*; #(
   parameter int N_RANGE_LOW  = 44,
   parameter int N_RANGE_MID  = 26,
   parameter int N_RANGE_HIGH = 16
) (
   input  logic                         clk,
   input  logic                         rst,
   input  logic [1:0]                   range_sel,
   input  logic [1:0]                   test_sel,
   input  logic                         ref_in,
   input  logic [LVL_W*NUM_PAIRS-1:0]   fsel_hi,
   input  logic [LVL_W*NUM_PAIRS-1:0]   fsel_lo,
   output logic [NUM_PAIRS-1:0]         q0,
   output logic [NUM_PAIRS-1:0]         q1
);
   localparam int N_MAX_LM = (N_RANGE_LOW > N_RANGE_MID) ? N_RANGE_LOW : N_RANGE_MID;
   localparam int N_MAX    = (N_MAX_LM > N_RANGE_HIGH) ? N_MAX_LM : N_RANGE_HIGH;
   localparam int PH_W     = $clog2(N_MAX + 1);
   localparam int SEL_W    = LVL_W * NUM_PAIRS;

   generate
      if ((N_RANGE_LOW % 2) != 0 || (N_RANGE_MID % 2) != 0 || (N_RANGE_HIGH % 2) != 0) begin : g_err_odd
         $error("skew_clk_matrix: every period length must be even");
      end
      if (N_RANGE_LOW < MIN_N || N_RANGE_MID < MIN_N || N_RANGE_HIGH < MIN_N) begin : g_err_short
         $error("skew_clk_matrix: period too short for the largest skew");
      end
   endgenerate

   logic            test_mode;
   logic            wrap;
   logic [PH_W-1:0] ph_cnt;
   logic [PH_W-1:0] n_act;
   logic [1:0]      dcnt;
   logic [1:0]      range_act;
   logic [SEL_W-1:0] sel_hi_act;
   logic [SEL_W-1:0] sel_lo_act;

   assign test_mode = (lvl_index(test_sel) != LVL_LOW);

   skm_phase_gen #(
      .N_LOW (N_RANGE_LOW),
      .N_MID (N_RANGE_MID),
      .N_HIGH(N_RANGE_HIGH),
      .PH_W  (PH_W)
   ) u_phase (
      .clk      (clk),
      .rst      (rst),
      .range_sel(range_sel),
      .test_mode(test_mode),
      .ref_in   (ref_in),
      .ph       (ph_cnt),
      .n_act    (n_act),
      .wrap     (wrap),
      .dcnt     (dcnt),
      .range_act(range_act)
   );

   always_ff @(posedge clk) begin
      if (rst || wrap) begin
         sel_hi_act <= fsel_hi;
         sel_lo_act <= fsel_lo;
      end
   end

   generate
      for (genvar p = 0; p < NUM_PAIRS; p++) begin : g_pair
         pair_cfg_t cfg;

         skm_func_decode #(.KIND(pair_kind(p))) u_dec (
            .code_hi(sel_hi_act[LVL_W*p +: LVL_W]),
            .code_lo(sel_lo_act[LVL_W*p +: LVL_W]),
            .cfg    (cfg)
         );

         skm_pair_out #(.PH_W(PH_W)) u_out (
            .clk      (clk),
            .rst      (rst),
            .cfg      (cfg),
            .ph       (ph_cnt),
            .n_act    (n_act),
            .dcnt     (dcnt),
            .test_mode(test_mode),
            .ref_in   (ref_in),
            .q0       (q0[p]),
            .q1       (q1[p])
         );
      end
   endgenerate
endmodule

// File: rtl/skew_clk_matrix_chk.sv
module skew_clk_matrix_chk #(
   parameter int PH_W = 6,
   parameter int NP   = 4,
   parameter int CFG_W = 2 + 4 * NP
) (
   input logic             clk,
   input logic             rst,
   input logic [1:0]       test_sel,
   input logic             ref_in,
   input logic [NP-1:0]    q0,
   input logic [NP-1:0]    q1,
   input logic [PH_W-1:0]  ph_cnt,
   input logic [PH_W-1:0]  n_act,
   input logic [1:0]       dcnt,
   input logic [CFG_W-1:0] cfg_act
);
   logic rst_d = 1'b0;

   always_ff @(posedge clk) rst_d <= rst;

   always @(posedge clk) begin
      if (rst_d) begin
         assert_reset_clear_R1: assert (q0 == '0 && q1 == '0 && ph_cnt == '0 && dcnt == '0)
            else $error("outputs or counters not cleared by reset");
      end
   end

   assert_pair_equal_R11: assert property (@(posedge clk) disable iff (rst)
      q0 == q1);

   assert_phase_bound_R3: assert property (@(posedge clk) disable iff (rst)
      ph_cnt < n_act);

   assert_phase_wrap_R3: assert property (@(posedge clk) disable iff (rst)
      (ph_cnt == n_act - 1'b1) |=> (ph_cnt == '0));

   assert_cfg_hold_R9: assert property (@(posedge clk) disable iff (rst)
      (ph_cnt != n_act - 1'b1) |=> $stable(cfg_act));

   assert_div_hold_R8: assert property (@(posedge clk) disable iff (rst)
      (test_sel == 2'b00 && ph_cnt != n_act - 1'b1) |=> $stable(dcnt));

   assert_bypass_ref_R10: assert property (@(posedge clk) disable iff (rst)
      (test_sel != 2'b00) |=> (q0[0] == $past(ref_in)));
endmodule

bind skew_clk_matrix skew_clk_matrix_chk #(.PH_W(PH_W), .NP(NUM_PAIRS)) u_chk (
   .clk     (clk),
   .rst     (rst),
   .test_sel(test_sel),
   .ref_in  (ref_in),
   .q0      (q0),
   .q1      (q1),
   .ph_cnt  (ph_cnt),
   .n_act   (n_act),
   .dcnt    (dcnt),
   .cfg_act ({range_act, sel_hi_act, sel_lo_act})
);

// File: tb/skew_clk_matrix_tb.sv
module skew_clk_matrix_tb;
   localparam int NL = 44;
   localparam int NM = 26;
   localparam int NH = 16;

   logic       clk = 1'b0;
   logic       rst = 1'b1;
   logic [1:0] range_sel = 2'd1;
   logic [1:0] test_sel = 2'd0;
   logic       ref_in = 1'b0;
   logic [7:0] fsel_hi = 8'h55;
   logic [7:0] fsel_lo = 8'h55;
   logic [3:0] q0, q1;

   int    n_checks = 0;
   int    n_fail = 0;
   string cur_req = "R1";

   int         m_ph = 0;
   int         m_d = 0;
   logic [1:0] m_rng = 2'd1;
   logic [7:0] m_hi = 8'h55;
   logic [7:0] m_lo = 8'h55;
   bit         m_refq = 1'b0;

   always #2 clk = ~clk;

   skew_clk_matrix u_dut (
      .clk(clk), .rst(rst), .range_sel(range_sel), .test_sel(test_sel),
      .ref_in(ref_in), .fsel_hi(fsel_hi), .fsel_lo(fsel_lo), .q0(q0), .q1(q1)
   );

   function automatic int lvl(input logic [1:0] c);
      return (c == 2'b11) ? 1 : int'(c);
   endfunction

   function automatic int per(input logic [1:0] r);
      int l = lvl(r);
      return (l == 0) ? NL : (l == 2) ? NH : NM;
   endfunction

   function automatic bit exp_bit(input int p, input int idx, input int ph, input int n,
                                  input int d, input bit tst, input bit r);
      int sk, v;
      if (p >= 2 && idx == 0) return (d % 2) == 1;
      if (p == 2 && idx == 8) return d < 2;
      if (p == 3 && idx == 8) return tst ? !r : !(ph < n / 2);
      sk = (p < 2) ? idx - 4 : 2 * idx - 8;
      if (tst) return r;
      v = (((ph - sk) % n) + n) % n;
      return v < n / 2;
   endfunction

   function automatic string pair_req(input int p, input int idx);
      if (p < 2) return "R4";
      if (idx == 8) return "R6";
      return "R5";
   endfunction

   task automatic check(input string req, input string sub, input int p, input logic act, input logic exp);
      n_checks++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s/%s pair %0d at %0t: actual %b expected %b", req, sub, p, $time, act, exp);
      end
   endtask

   task automatic step();
      logic [3:0] nxt;
      string subs [4];
      int n, idx;
      bit wrap, tst;
      n = per(m_rng);
      tst = (test_sel != 2'b00);
      for (int p = 0; p < 4; p++) begin
         idx = 3 * lvl(m_hi[2*p +: 2]) + lvl(m_lo[2*p +: 2]);
         nxt[p] = exp_bit(p, idx, m_ph, n, m_d, tst, ref_in);
         subs[p] = pair_req(p, idx);
      end
      if (rst) begin
         m_ph = 0; m_d = 0; m_refq = 1'b0;
         m_rng = range_sel; m_hi = fsel_hi; m_lo = fsel_lo;
         nxt = 4'b0000;
      end else begin
         wrap = (m_ph == n - 1);
         m_ph = wrap ? 0 : m_ph + 1;
         if (wrap) begin
            m_rng = range_sel; m_hi = fsel_hi; m_lo = fsel_lo;
         end
         if (tst) begin
            if (ref_in && !m_refq) m_d = (m_d + 1) % 4;
         end else if (wrap) begin
            m_d = (m_d + 1) % 4;
         end
         m_refq = ref_in;
      end
      @(posedge clk);
      @(negedge clk);
      for (int p = 0; p < 4; p++) begin
         check(cur_req, subs[p], p, q0[p], nxt[p]);
         check("R11", "pair", p, q1[p], q0[p]);
      end
   endtask

   task automatic set_combo(input int k, input int c, input bit use11);
      logic [1:0] h, l;
      h = (c / 3 == 1 && use11) ? 2'b11 : 2'(c / 3);
      l = (c % 3 == 1 && use11) ? 2'b11 : 2'(c % 3);
      fsel_hi[2*k +: 2] = h;
      fsel_lo[2*k +: 2] = l;
   endtask

   task automatic finish_run();
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fail);
      $finish;
   endtask

   initial begin
      #(200000 * 4);
      n_checks++;
      n_fail++;
      $display("FAIL watchdog: run did not finish, actual hung expected done");
      finish_run();
   end

   initial begin
      logic [3:0] prev;
      // R1: reset holds outputs low, then zero phase starts
      cur_req = "R1";
      repeat (3) step();
      rst = 1'b0;
      repeat (4) step();

      // R3: every range with every function, selects changed mid-period
      cur_req = "R3";
      for (int r = 0; r < 3; r++) begin
         range_sel = 2'(r);
         for (int c = 0; c < 9; c++) begin
            for (int k = 0; k < 4; k++) set_combo(k, (c + k) % 9, 1'b0);
            repeat (4 * per(2'(r)) + 5) step();
         end
      end

      // R2: code 11 acts as MID on range and selects
      cur_req = "R2";
      range_sel = 2'b11;
      for (int c = 0; c < 9; c++) begin
         for (int k = 0; k < 4; k++) set_combo(k, c, 1'b1);
         repeat (2 * NM + 5) step();
      end

      // R7: skew arithmetic with wraparound at the longest period
      cur_req = "R7";
      range_sel = 2'b00;
      for (int c = 0; c < 9; c++) begin
         for (int k = 0; k < 4; k++) set_combo(k, (8 - c + k) % 9, 1'b0);
         repeat (2 * NL + 3) step();
      end

      // R9: irregular mid-period changes take effect only at wrap
      cur_req = "R9";
      for (int i = 0; i < 20; i++) begin
         range_sel = 2'(i % 3);
         for (int k = 0; k < 4; k++) set_combo(k, (i * 5 + k) % 9, i[0]);
         repeat ((i * 7) % 23 + 1) step();
      end

      // R8: divide-by-4 on pair 2, divide-by-2 on pair 3 ... pair 3 LL
      cur_req = "R8";
      range_sel = 2'b01;
      set_combo(0, 4, 1'b0); set_combo(1, 4, 1'b0);
      set_combo(2, 8, 1'b0); set_combo(3, 0, 1'b0);
      repeat (2 * NL) step();
      prev = q0;
      for (int i = 0; i < 12 * NM; i++) begin
         step();
         if (prev[2] && !q0[2]) begin
            n_checks++;
            if (!(prev[3] && !q0[3])) begin
               n_fail++;
               $display("FAIL R8 falling edges apart: actual div2 %b->%b expected 1->0", prev[3], q0[3]);
            end
         end
         prev = q0;
      end

      // R10: bypass with each non-LOW test code
      cur_req = "R10";
      for (int t = 1; t < 4; t++) begin
         test_sel = 2'(t);
         set_combo(0, t, 1'b0); set_combo(1, 8 - t, 1'b0);
         set_combo(2, (t == 2) ? 0 : 8, 1'b0); set_combo(3, (t == 3) ? 0 : 8, 1'b0);
         for (int i = 0; i < 150; i++) begin
            ref_in = ((i / 3) % 2) == 1;
            step();
         end
      end
      test_sel = 2'b00;
      ref_in = 1'b0;
      repeat (3 * NL) step();

      finish_run();
   end
endmodule